// File: doc/BRIEF.md
# First-Word-Fall-Through Adapter around a Registered-Read FIFO

This block gives a consumer a queue in which the oldest stored word is always shown at the output, without the consumer having to request it first. Inside it sits an ordinary synchronous FIFO whose read data appears one clock after its read strobe. Around that core, a small prefetch controller and a short chain of holding stages move the head word forward as soon as room exists. The core's data path is not altered. Only the read strobe, the empty and full flags and the occupancy count are re-derived.

The consumer sees `empty` low together with a valid `q`. Raising `rd` in that same cycle takes the shown word, and the next word can be shown on the following edge. A parameter selects one or two holding stages. With two stages, `q` comes from a flop that is fed only by another flop, at the cost of one more cycle of latency. A synchronous `clr` discards everything held in the core and in the adapter in a single edge.

Top module: `fwft_adapter`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `used` is 0.
- R2: With `OUT_REG` = 0, a word written into an otherwise empty adapter on clock edge E drives `empty` low and appears on `q` after edge E+2, and not earlier.
- R3: With `OUT_REG` = 1, the same word appears, with `empty` low, after edge E+3, and not earlier.
- R4: Words leave in the order they were accepted. Whenever `empty` is 0, `q` holds the oldest stored word, and an edge with `rd` high removes exactly that word.
- R5: `rd` while `empty` is 1 removes nothing and leaves `used` unchanged by the read.
- R6: `full` is the core's full flag. Once the block has been idle, `full` is 1 exactly when `DEPTH + OUT_REG + 2` words are stored. A write while `full` is 1 is dropped.
- R7: `used` equals the number of words stored in the core plus the words held by the adapter (the one in flight on the core's output and those in the holding stages).
- R8: An edge with `clr` high leaves `used` at 0 and `empty` at 1. A write presented on that same edge is dropped.
- R9: While `rd` is low and `clr` is low, a shown word stays on `q` with `empty` low. With enough words stored, `rd` held high removes one word on every edge with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all stored words |
| wr | input | 1 | Write strobe, ignored while full |
| din | input | DW | Write data |
| rd | input | 1 | Takes the word shown on q, ignored while empty |
| q | output | DW | Oldest stored word, valid while empty is low |
| empty | output | 1 | No word is shown on q |
| full | output | 1 | Core FIFO cannot accept a write |
| used | output | $clog2(DEPTH+OUT_REG+3) | Total words stored |

## Verification
A lost or duplicated valid bit in the prefetch slot or in a holding stage shows up at once as a mismatch between `used` and the number of words accepted but not yet taken. On the next read it also shows up as a skipped or repeated value on `q`. A prefetch that is issued late or blocked wrongly moves the edge on which `empty` falls after a write, so latency errors appear within three cycles of the first write. A wrong full decision only becomes visible once the queue has settled. The bench therefore compares `full` against the stored count after a few idle cycles and follows every accepted word to its exit.

// File: rtl/fwft_pkg.sv
package fwft_pkg;

  // Pointer width for a memory of n entries (at least one bit).
  function automatic int addr_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Width of the total occupancy: core depth, one in-flight slot, and nst stages.
  function automatic int used_w(input int depth, input int nst);
    return $clog2(depth + nst + 2);
  endfunction

endpackage

// File: rtl/fwft_core_fifo.sv
// Registered-read synchronous FIFO: read data is on q one edge after rd.
module fwft_core_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         wr,
  input  logic [DW-1:0]                din,
  input  logic                         rd,
  output logic [DW-1:0]                q,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   used
);

  localparam int AW = fwft_pkg::addr_w(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] q_q;
  logic          wr_ok, rd_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign used  = cnt_q;
  assign q     = q_q;

  assign wr_ok = wr && !full && !clr;
  assign rd_ok = rd && !empty && !clr;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (wr_ok) wptr_d = bump(wptr_q);
      if (rd_ok) rptr_d = bump(rptr_q);
      cnt_d = cnt_q + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // Storage array: write-enabled, no reset.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= din;
  end

  // Read register: loads only on an accepted read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_q <= '0;
    else if (rd_ok) q_q <= mem[rptr_q];
  end

  // R6: a write on a full core, with no read and no clear, changes nothing
  a_r6_drop_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !rd && !clr) |=> (cnt_q == $past(cnt_q)));

  // R7: the core count never exceeds its depth
  a_r7_core_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/fwft_prefetch.sv
// Tracks the word in flight on the core's read register and issues core reads.
module fwft_prefetch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic core_empty,
  input  logic stage_ready,
  output logic core_rd,
  output logic pend
);

  logic pend_q, pend_d;
  logic take;

  // The in-flight word leaves the core register when the first stage accepts it.
  assign take    = pend_q && stage_ready;
  // Refill the core register whenever it is free or being emptied this edge.
  assign core_rd = !clr && !core_empty && (!pend_q || stage_ready);

  always_comb begin
    pend_d = pend_q;
    if (clr)          pend_d = 1'b0;
    else if (core_rd) pend_d = 1'b1;
    else if (take)    pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R4: a word in flight that is not accepted is never lost
  a_r4_inflight_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !stage_ready && !clr) |=> pend_q);

  // R8: clear drops the word in flight
  a_r8_clear_drops_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pend_q);

endmodule

// File: rtl/fwft_stage.sv
// One holding stage of the output chain with a ready/valid hand-off.
module fwft_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          out_ready,
  output logic          valid,
  output logic [DW-1:0] data
);

  logic          v_q, v_d;
  logic [DW-1:0] d_q;
  logic          load;

  assign in_ready = !v_q || out_ready;
  assign load     = in_valid && in_ready && !clr;

  always_comb begin
    v_d = v_q;
    if (clr)            v_d = 1'b0;
    else if (load)      v_d = 1'b1;
    else if (out_ready) v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    d_q <= '0;
    else if (load) d_q <= in_data;
  end

  assign valid = v_q;
  assign data  = d_q;

  // R9: a held word that is not passed on stays put
  a_r9_stage_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !out_ready && !clr) |=> (v_q && $stable(d_q)));

endmodule

// File: rtl/fwft_adapter.sv
// Top: registered-read core FIFO with prefetch and a holding chain of 1 or 2 stages.
module fwft_adapter #(
  parameter int DW      = 8,
  parameter int DEPTH   = 8,
  parameter int OUT_REG = 0
) (
  input  logic                                               clk,
  input  logic                                               rst_n,
  input  logic                                               clr,
  input  logic                                               wr,
  input  logic [DW-1:0]                                      din,
  input  logic                                               rd,
  output logic [DW-1:0]                                      q,
  output logic                                               empty,
  output logic                                               full,
  output logic [fwft_pkg::used_w(DEPTH, 1 + OUT_REG)-1:0]    used
);

  localparam int NST    = (OUT_REG != 0) ? 2 : 1;
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int USED_W = fwft_pkg::used_w(DEPTH, 1 + OUT_REG);
  localparam int CAP    = DEPTH + NST + 1;

  logic [DW-1:0]  core_q;
  logic           core_empty, core_full, core_rd;
  logic [CW-1:0]  core_used;
  logic           pend;
  logic           pop;

  logic [NST-1:0] st_v, st_rdy;
  logic [DW-1:0]  st_d [NST];

  fwft_core_fifo #(.DW(DW), .DEPTH(DEPTH)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .wr    (wr),
    .din   (din),
    .rd    (core_rd),
    .q     (core_q),
    .empty (core_empty),
    .full  (core_full),
    .used  (core_used)
  );

  fwft_prefetch u_pf (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .core_empty  (core_empty),
    .stage_ready (st_rdy[0]),
    .core_rd     (core_rd),
    .pend        (pend)
  );

  assign pop = rd && st_v[NST-1] && !clr;

  for (genvar k = 0; k < NST; k++) begin : g_stage
    logic          in_v;
    logic [DW-1:0] in_d;
    logic          out_r;
    if (k == 0) begin : g_first
      assign in_v = pend;
      assign in_d = core_q;
    end else begin : g_next
      assign in_v = st_v[k-1];
      assign in_d = st_d[k-1];
    end
    if (k == NST - 1) begin : g_last
      assign out_r = pop;
    end else begin : g_mid
      assign out_r = st_rdy[k+1];
    end
    fwft_stage #(.DW(DW)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .in_valid  (in_v),
      .in_data   (in_d),
      .in_ready  (st_rdy[k]),
      .out_ready (out_r),
      .valid     (st_v[k]),
      .data      (st_d[k])
    );
  end

  assign q     = st_d[NST-1];
  assign empty = !st_v[NST-1];
  assign full  = core_full;
  assign used  = USED_W'(core_used) + USED_W'(pend) + USED_W'($countones(st_v));

  // R8: clear leaves nothing stored and nothing shown
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (used == '0 && empty));

  // R5: a read on an empty output removes nothing
  a_r5_read_empty_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd && !clr) |=> (used >= $past(used)));

  // R7: total occupancy never exceeds core depth plus adapter slots
  a_r7_used_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    used <= USED_W'(CAP));

  // R9: a shown word with no read and no clear stays shown
  a_r9_shown_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !rd && !clr) |=> (!empty && $stable(q)));

endmodule

// File: tb/fwft_adapter_chk.sv
// Harness: one DUT plus a behavioural queue model compared on every cycle.
module fwft_adapter_chk #(
  parameter int DW      = 8,
  parameter int DEPTH   = 8,
  parameter int OUT_REG = 0
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            clr,
  input  logic                                            wr,
  input  logic [DW-1:0]                                   din,
  input  logic                                            rd,
  output logic [DW-1:0]                                   q,
  output logic                                            empty,
  output logic                                            full,
  output logic [fwft_pkg::used_w(DEPTH, 1 + OUT_REG)-1:0] used,
  output int                                              n_chk,
  output int                                              n_fail
);

  localparam int    NST  = (OUT_REG != 0) ? 2 : 1;
  localparam int    LAT  = NST + 1;
  localparam int    CAP  = DEPTH + NST + 1;
  localparam string LTAG = (OUT_REG != 0) ? "R3" : "R2";

  fwft_adapter #(.DW(DW), .DEPTH(DEPTH), .OUT_REG(OUT_REG)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr(wr), .din(din), .rd(rd),
    .q(q), .empty(empty), .full(full), .used(used)
  );

  int    md[$];
  int    mw[$];
  int    cyc   = 0;
  int    quiet = 0;
  string ptag  = "R1";
  bit    mvis  = 1'b0;
  bit    s_full = 1'b0;

  initial begin
    n_chk  = 0;
    n_fail = 0;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s OUT_REG=%0d %s actual=%0h expected=%0h t=%0t",
               tag, OUT_REG, what, act, exp, $time);
    end
  endtask

  // Model update on each edge, from inputs and flags sampled before the edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      md.delete();
      mw.delete();
      cyc   = 0;
      quiet = 0;
      ptag  = "R1";
    end else begin
      cyc++;
      if (clr) begin
        md.delete();
        mw.delete();
        ptag = "R8";
      end else begin
        ptag = "R7";
        if (rd && mvis) begin
          void'(md.pop_front());
          void'(mw.pop_front());
        end else if (rd) begin
          ptag = "R5";
        end
        if (wr && !s_full) begin
          md.push_back(int'(din));
          mw.push_back(cyc);
        end else if (wr) begin
          ptag = "R6";
        end
      end
      quiet = (wr || rd || clr) ? 0 : quiet + 1;
    end
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    s_full = full;
    mvis   = 1'b0;
    if (md.size() > 0) mvis = (cyc >= mw[0] + LAT);
    if (rst_n) begin
      chk(empty == !mvis, LTAG, "empty", longint'(empty), longint'(!mvis));
      if (mvis) chk(q == DW'(md[0]), "R4", "q head", longint'(q), longint'(md[0]));
      chk(int'(used) == md.size(), ptag, "used", longint'(used), longint'(md.size()));
      if (quiet >= 6)
        chk(full == (md.size() >= CAP), "R6", "settled full",
            longint'(full), longint'(md.size() >= CAP));
    end
  end

endmodule

// File: tb/fwft_adapter_tb.sv
module fwft_adapter_tb;

  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int UWB   = fwft_pkg::used_w(DEPTH, 1);
  localparam int UWR   = fwft_pkg::used_w(DEPTH, 2);

  logic          clk   = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr   = 1'b0;
  logic          wr    = 1'b0;
  logic          rd    = 1'b0;
  logic [DW-1:0] din   = '0;

  logic [DW-1:0]  qb, qr;
  logic           eb, er, fb, fr;
  logic [UWB-1:0] ub;
  logic [UWR-1:0] ur;
  int             cb, xb, cr, xr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fwft_adapter_chk #(.DW(DW), .DEPTH(DEPTH), .OUT_REG(0)) u_base (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr(wr), .din(din), .rd(rd),
    .q(qb), .empty(eb), .full(fb), .used(ub), .n_chk(cb), .n_fail(xb)
  );

  fwft_adapter_chk #(.DW(DW), .DEPTH(DEPTH), .OUT_REG(1)) u_reg (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr(wr), .din(din), .rd(rd),
    .q(qr), .empty(er), .full(fr), .used(ur), .n_chk(cr), .n_fail(xr)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Called at a falling edge: drive inputs, return at the next falling edge.
  task automatic step(input bit w, input bit r, input bit c, input logic [DW-1:0] d);
    wr  = w;
    rd  = r;
    clr = c;
    din = d;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks + cb + cr, fails + xb + xr);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(eb == 1'b1 && er == 1'b1, "R1", "empty after reset", {eb, er}, 2'b11);
    chk(fb == 1'b0 && fr == 1'b0, "R1", "full after reset", {fb, fr}, 0);
    chk(ub == '0 && ur == '0, "R1", "used after reset", ub + ur, 0);

    // R2 / R3: write-to-visible latency
    step(1, 0, 0, 8'hA5);                  // state after write edge E
    chk(eb && er, "R2", "empty after E", {eb, er}, 2'b11);
    step(0, 0, 0, 0);                      // after E+1
    chk(eb && er, "R2", "empty after E+1", {eb, er}, 2'b11);
    step(0, 0, 0, 0);                      // after E+2
    chk(!eb && qb == 8'hA5, "R2", "base shows word after E+2", {eb, qb}, 9'h0A5);
    chk(er, "R3", "registered still empty after E+2", er, 1);
    step(0, 0, 0, 0);                      // after E+3
    chk(!er && qr == 8'hA5, "R3", "registered shows word after E+3", {er, qr}, 9'h0A5);

    // R9: shown word holds while rd low
    repeat (3) step(0, 0, 0, 0);
    chk(!eb && !er && qb == 8'hA5 && qr == 8'hA5, "R9", "held word", {qb, qr}, 16'hA5A5);

    // R4: pop leaves both empty
    step(0, 1, 0, 0);
    chk(eb && er && ub == '0 && ur == '0, "R4", "popped single word", ub + ur, 0);

    // R5: reads on empty do nothing
    repeat (3) step(0, 1, 0, 0);
    chk(eb && er && ub == '0 && ur == '0, "R5", "read on empty", ub + ur, 0);

    // R6: fill beyond capacity
    for (int i = 0; i < 16; i++) step(1, 0, 0, DW'(8'h10 + i));
    repeat (6) step(0, 0, 0, 0);
    chk(fb && int'(ub) == DEPTH + 2, "R6", "base capacity", ub, DEPTH + 2);
    chk(fr && int'(ur) == DEPTH + 3, "R6", "registered capacity", ur, DEPTH + 3);

    // R9: continuous drain, one word per edge
    for (int i = 0; i < DEPTH + 2; i++) begin
      chk(!eb && qb == DW'(8'h10 + i), "R9", "base back-to-back head", qb, 8'h10 + i);
      chk(!er && qr == DW'(8'h10 + i), "R9", "reg back-to-back head", qr, 8'h10 + i);
      step(0, 1, 0, 0);
    end
    chk(eb && ub == '0, "R4", "base drained", ub, 0);
    chk(!er && qr == DW'(8'h10 + DEPTH + 2), "R4", "reg last word", qr, 8'h10 + DEPTH + 2);
    step(0, 1, 0, 0);

    // R8: clear with a write on the same edge
    for (int i = 0; i < 4; i++) step(1, 0, 0, DW'(8'h40 + i));
    repeat (4) step(0, 0, 0, 0);
    step(1, 0, 1, 8'hEE);
    chk(eb && er && ub == '0 && ur == '0, "R8", "clear empties", ub + ur, 0);
    repeat (4) step(0, 0, 0, 0);
    chk(eb && er && ub == '0 && ur == '0, "R8", "write on clear edge dropped", ub + ur, 0);

    // Mixed traffic, compared against the models on every cycle
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 10) < 6, ($urandom % 10) < 5, ($urandom % 97) == 0, DW'($urandom));
    end
    repeat (8) step(0, 0, 0, 0);

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

endmodule